// File: doc/BRIEF.md
# Serial ATA Link Bring-Up Sequencer

This block walks one serial ATA port from power-on to an established link without software involvement. On a start pulse it clears the port error register and pulses the PHY's COMRESET request through a control register. It then releases that request and verifies the release by reading the register back. After a settle interval it polls the PHY's detect status once per millisecond until a link appears or the poll budget runs out.

A device that is present but never forms a link gets one more chance. The sequencer pins the control register to a first-generation speed limit, drops the second-generation enable, pulses a channel reset and runs the whole attempt again. The outcome is reported as a one-cycle done pulse with a 2-bit code. Every wait is a count of pulses on a millisecond tick input, so the block needs no knowledge of the clock frequency.

The control register itself lives outside the block. The sequencer writes it with a one-cycle strobe and reads its current value back on a plain input bus. Each attempt goes through these steps in a fixed order:

1. Clear the error register.
2. Assert the reset request.
3. Hold it.
4. Release it and verify the release, repeating as needed.
5. Settle.
6. Poll the detect status.

Top module: `sata_linkup_seq`

## Requirements
- R1: After reset every strobe output is low, `result_o` is 00 and `gen2_en_o` is 1.
- R2: A `start_i` pulse seen in idle raises `err_clr_o` for exactly the next cycle. The following cycle writes the control register with bits [11:10]=00, [9:8]=11, [7:4] copied from `ctl_rdata_i[7:4]` and [3:0]=0001. `gen2_en_o` is 1 for the whole new sequence until a fallback.
- R3: The reset request is held for `RST_MS` ticks after that write. Then a release write goes out with [3:0]=0000, [9:8]=11, [11:10]=00 and [7:4] preserved from the readback.
- R4: `REL_MS` ticks after each release write, the readback is checked. If `ctl_rdata_i[11:8]`=0011 and `ctl_rdata_i[3:0]`=0000, the sequence moves on. Otherwise the release write is repeated, up to `REL_RETRIES` extra times. After the last one the sequence moves on regardless.
- R5: `SETTLE_MS` ticks after the release phase ends, `det_i` is sampled on each tick, for at most `POLLS` samples. A sample of 3 ends the sequence with result 01 (found).
- R6: If the last of the `POLLS` samples is 0, the result is 10 (no device) and no fallback occurs.
- R7: If the last sample is any value other than 0 or 3 on the first attempt, a single cycle writes 0x304 to the control register and pulses `chan_rst_o`. `gen2_en_o` drops to 0 from the next cycle, and the sequence restarts at the error clear.
- R8: The same condition on the second attempt ends the sequence with result 11 (failed). There is never a third attempt.
- R9: `done_o` is a one-cycle pulse, and `result_o` holds the code from that cycle until the next result. A `start_i` pulse while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a bring-up sequence (accepted in idle only) |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| det_i | input | 4 | Detect status field from the PHY (3 = link up, 0 = nothing attached) |
| ctl_rdata_i | input | 12 | Current value of the port control register |
| err_clr_o | output | 1 | Write zero to the port error register |
| ctl_wr_o | output | 1 | Control register write strobe |
| ctl_wdata_o | output | 12 | Control register write data |
| gen2_en_o | output | 1 | Second-generation speed enable |
| chan_rst_o | output | 1 | Channel reset pulse |
| done_o | output | 1 | Sequence finished (one cycle) |
| result_o | output | 2 | 01 found, 10 no device, 11 failed, 00 none yet |

## Verification
The bench holds the release readback's detect bits nonzero for a chosen number of writes. A design that retried one time too many or too few would show a wrong release-write count, and one that stalled on a stuck readback would never finish. Scenarios with detect values of 0, a link on the second attempt, a persistent non-link value on both attempts, and a fallback that ends in "no device" pin down the result-code decision. A design that retried on "no device", allowed a third attempt, or failed to restore the speed enable at the next start would diverge from the cycle-by-cycle reference. Start pulses injected during a running sequence catch a design that restarts or emits a second done.

// File: rtl/sata_lu_pkg.sv
package sata_lu_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR,
    ST_ASSERT,
    ST_WRST,
    ST_REL,
    ST_WREL,
    ST_CHK,
    ST_WSET,
    ST_POLL,
    ST_FB,
    ST_DONE
  } lu_state_e;

  localparam logic [1:0] RES_NONE  = 2'b00;
  localparam logic [1:0] RES_FOUND = 2'b01;
  localparam logic [1:0] RES_NODEV = 2'b10;
  localparam logic [1:0] RES_FAIL  = 2'b11;

  localparam logic [3:0]  DET_LINK     = 4'h3;
  localparam logic [3:0]  DET_ABSENT   = 4'h0;
  localparam logic [11:0] CTL_FALLBACK = 12'h304;
  localparam logic [11:0] CTL_REL_MASK = 12'hF0F;
  localparam logic [11:0] CTL_REL_OK   = 12'h300;

endpackage

// File: rtl/sata_lu_tickcnt.sv
module sata_lu_tickcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  assign last_o = run_i && tick_i && (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (last_o)      cnt_q <= '0;
    else if (tick_i)      cnt_q <= cnt_q + CW'(1);
  end

  // window count never reaches the limit it is compared against (R3)
  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/sata_lu_fsm.sv
module sata_lu_fsm
  import sata_lu_pkg::*;
#(
  parameter int RST_MS      = 1,
  parameter int REL_MS      = 10,
  parameter int SETTLE_MS   = 10,
  parameter int POLLS       = 200,
  parameter int REL_RETRIES = 5,
  parameter int CW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic [3:0]    det_i,
  input  logic [11:0]   ctl_rdata_i,
  input  logic          last_i,
  output logic          run_o,
  output logic [CW-1:0] limit_o,
  output logic          err_clr_o,
  output logic          ctl_wr_o,
  output logic [11:0]   ctl_wdata_o,
  output logic          gen2_en_o,
  output logic          chan_rst_o,
  output logic          done_o,
  output logic [1:0]    result_o
);

  localparam int RW = $clog2(REL_RETRIES + 2);

  lu_state_e      st_q, st_d;
  logic [RW-1:0]  retry_q;
  logic           fb_q;
  logic           gen2_q;
  logic [1:0]     res_q, res_d;
  logic           rel_ok;
  logic           rel_exit;

  assign rel_ok   = (ctl_rdata_i & CTL_REL_MASK) == CTL_REL_OK;
  assign rel_exit = rel_ok || (retry_q == RW'(REL_RETRIES));

  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_CLR;
      ST_CLR:    st_d = ST_ASSERT;
      ST_ASSERT: st_d = ST_WRST;
      ST_WRST:   if (last_i) st_d = ST_REL;
      ST_REL:    st_d = ST_WREL;
      ST_WREL:   if (last_i) st_d = ST_CHK;
      ST_CHK:    st_d = rel_exit ? ST_WSET : ST_REL;
      ST_WSET:   if (last_i) st_d = ST_POLL;
      ST_POLL: begin
        if (tick_i) begin
          if (det_i == DET_LINK) begin
            st_d  = ST_DONE;
            res_d = RES_FOUND;
          end else if (last_i) begin
            if (det_i == DET_ABSENT) begin
              st_d  = ST_DONE;
              res_d = RES_NODEV;
            end else if (fb_q) begin
              st_d  = ST_DONE;
              res_d = RES_FAIL;
            end else begin
              st_d  = ST_FB;
            end
          end
        end
      end
      ST_FB:     st_d = ST_CLR;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      retry_q <= '0;
      fb_q    <= 1'b0;
      gen2_q  <= 1'b1;
      res_q   <= RES_NONE;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
      if (st_q == ST_IDLE && start_i) begin
        fb_q   <= 1'b0;
        gen2_q <= 1'b1;
      end
      if (st_q == ST_FB) begin
        fb_q   <= 1'b1;
        gen2_q <= 1'b0;
      end
      if (st_q == ST_ASSERT)               retry_q <= '0;
      else if (st_q == ST_CHK && !rel_exit) retry_q <= retry_q + RW'(1);
    end
  end

  always_comb begin
    case (st_q)
      ST_WRST: limit_o = CW'(RST_MS);
      ST_WREL: limit_o = CW'(REL_MS);
      ST_WSET: limit_o = CW'(SETTLE_MS);
      default: limit_o = CW'(POLLS);
    endcase
  end

  assign run_o = (st_q == ST_WRST) || (st_q == ST_WREL) ||
                 (st_q == ST_WSET) || (st_q == ST_POLL);

  always_comb begin
    case (st_q)
      ST_ASSERT: ctl_wdata_o = {4'b0011, ctl_rdata_i[7:4], 4'b0001};
      ST_REL:    ctl_wdata_o = {4'b0011, ctl_rdata_i[7:4], 4'b0000};
      ST_FB:     ctl_wdata_o = CTL_FALLBACK;
      default:   ctl_wdata_o = '0;
    endcase
  end

  assign ctl_wr_o   = (st_q == ST_ASSERT) || (st_q == ST_REL) || (st_q == ST_FB);
  assign err_clr_o  = (st_q == ST_CLR);
  assign chan_rst_o = (st_q == ST_FB);
  assign done_o     = (st_q == ST_DONE);
  assign gen2_en_o  = gen2_q;
  assign result_o   = res_q;

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_clr_o, ctl_wr_o, done_o}));

  assert_clr_then_assert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_o |=> (ctl_wr_o && ctl_wdata_o[9:8] == 2'b11 && ctl_wdata_o[3:0] == 4'h1));

  assert_retry_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q <= RW'(REL_RETRIES));

  assert_fb_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst_o |=> (err_clr_o && !gen2_en_o));

  assert_fail_after_fb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == RES_FAIL) |-> !gen2_en_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/sata_linkup_seq.sv
module sata_linkup_seq #(
  parameter int RST_MS      = 1,
  parameter int REL_MS      = 10,
  parameter int SETTLE_MS   = 10,
  parameter int POLLS       = 200,
  parameter int REL_RETRIES = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        ms_tick_i,
  input  logic [3:0]  det_i,
  input  logic [11:0] ctl_rdata_i,
  output logic        err_clr_o,
  output logic        ctl_wr_o,
  output logic [11:0] ctl_wdata_o,
  output logic        gen2_en_o,
  output logic        chan_rst_o,
  output logic        done_o,
  output logic [1:0]  result_o
);

  localparam int MAX_A  = (RST_MS > REL_MS) ? RST_MS : REL_MS;
  localparam int MAX_B  = (SETTLE_MS > POLLS) ? SETTLE_MS : POLLS;
  localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW     = $clog2(MAX_W + 1);

  logic          run;
  logic          last;
  logic [CW-1:0] limit;

  sata_lu_tickcnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .tick_i  (ms_tick_i),
    .limit_i (limit),
    .last_o  (last)
  );

  sata_lu_fsm #(
    .RST_MS      (RST_MS),
    .REL_MS      (REL_MS),
    .SETTLE_MS   (SETTLE_MS),
    .POLLS       (POLLS),
    .REL_RETRIES (REL_RETRIES),
    .CW          (CW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tick_i      (ms_tick_i),
    .det_i       (det_i),
    .ctl_rdata_i (ctl_rdata_i),
    .last_i      (last),
    .run_o       (run),
    .limit_o     (limit),
    .err_clr_o   (err_clr_o),
    .ctl_wr_o    (ctl_wr_o),
    .ctl_wdata_o (ctl_wdata_o),
    .gen2_en_o   (gen2_en_o),
    .chan_rst_o  (chan_rst_o),
    .done_o      (done_o),
    .result_o    (result_o)
  );

endmodule

// File: tb/sata_linkup_seq_bench.sv
`timescale 1ns/1ps
module sata_linkup_seq_bench;

  localparam int RST_MS = 1, REL_MS = 10, SETTLE_MS = 10, POLLS = 200, RETRIES = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ms_tick_i = 1'b0;
  logic [3:0] det_i;
  logic [11:0] ctl_rdata;
  logic err_clr_o, ctl_wr_o, gen2_en_o, chan_rst_o, done_o;
  logic [11:0] ctl_wdata_o;
  logic [1:0] result_o;

  always #10 clk = ~clk;

  sata_linkup_seq u_sata_linkup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ms_tick_i(ms_tick_i),
    .det_i(det_i), .ctl_rdata_i(ctl_rdata), .err_clr_o(err_clr_o),
    .ctl_wr_o(ctl_wr_o), .ctl_wdata_o(ctl_wdata_o), .gen2_en_o(gen2_en_o),
    .chan_rst_o(chan_rst_o), .done_o(done_o), .result_o(result_o)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  // millisecond tick: one cycle in five
  int div = 0;
  always @(negedge clk) begin
    div = (div == 4) ? 0 : div + 1;
    ms_tick_i = (div == 4);
  end

  // environment: control register, stuck release readback, detect source
  logic [11:0] ctl_q;
  logic stuck_flag, phase2, env_clr;
  int stuck_cfg = 0, stuck_left = 0, rel_wr_n = 0, crst_n = 0;
  logic [3:0] det_a = 4'h0, det_b = 4'h0;
  assign ctl_rdata = ctl_q | {11'b0, stuck_flag};
  assign det_i = phase2 ? det_b : det_a;

  initial env_clr = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= 12'h0A0; stuck_flag <= 1'b0; phase2 <= 1'b0;
    end else if (env_clr) begin
      stuck_left <= stuck_cfg; phase2 <= 1'b0; rel_wr_n <= 0; crst_n <= 0;
    end else begin
      if (ctl_wr_o) begin
        ctl_q <= ctl_wdata_o;
        if (ctl_wdata_o[3:0] == 4'h0 && ctl_wdata_o[9:8] == 2'b11) begin
          rel_wr_n <= rel_wr_n + 1;
          stuck_flag <= (stuck_left > 0);
          if (stuck_left > 0) stuck_left <= stuck_left - 1;
        end else stuck_flag <= 1'b0;
      end
      if (chan_rst_o) begin phase2 <= 1'b1; crst_n <= crst_n + 1; end
    end
  end

  // behavioural reference model
  logic m_on = 1'b0;
  logic e_clr = 0, e_wr = 0, e_crst = 0, e_done = 0, e_gen2 = 1;
  logic [11:0] e_wdata = '0;
  logic [1:0] e_res = 2'b00;

  task automatic step(); @(posedge clk); #1; endtask
  task automatic quiet(); e_clr = 0; e_wr = 0; e_crst = 0; e_done = 0; endtask
  task automatic wait_ms(input int n);
    int k = 0;
    while (k < n) begin quiet(); step(); if (ms_tick_i) k++; end
  endtask

  task automatic run_seq();
    bit fb = 0;
    int code;
    e_gen2 = 1;
    forever begin
      quiet(); e_clr = 1; step();
      quiet(); e_wr = 1; e_wdata = {4'b0011, ctl_rdata[7:4], 4'h1}; step();
      wait_ms(RST_MS);
      for (int w = 0; w <= RETRIES; w++) begin
        bit ok;
        quiet(); e_wr = 1; e_wdata = {4'b0011, ctl_rdata[7:4], 4'h0}; step();
        wait_ms(REL_MS);
        quiet(); ok = ((ctl_rdata & 12'hF0F) == 12'h300); step();
        if (ok) break;
      end
      wait_ms(SETTLE_MS);
      code = 0;
      for (int p = 0; code == 0; ) begin
        quiet(); step();
        if (ms_tick_i) begin
          p++;
          if (det_i == 4'h3) code = 1;
          else if (p == POLLS) code = (det_i == 4'h0) ? 2 : (fb ? 3 : 4);
        end
      end
      if (code == 4) begin
        quiet(); e_wr = 1; e_wdata = 12'h304; e_crst = 1; step();
        e_gen2 = 0; fb = 1;
      end else begin
        quiet(); e_done = 1; e_res = 2'(code); step();
        quiet();
        return;
      end
    end
  endtask

  initial begin
    wait (m_on);
    forever begin
      quiet(); step();
      if (start_i) run_seq();
    end
  end

  always @(negedge clk) if (m_on) begin
    chk(err_clr_o == e_clr, "R2 err_clr", err_clr_o, e_clr);
    chk(ctl_wr_o == e_wr, "R3/R4 ctl_wr", ctl_wr_o, e_wr);
    if (e_wr) chk(ctl_wdata_o == e_wdata, "R3/R7 ctl_wdata", ctl_wdata_o, e_wdata);
    chk(chan_rst_o == e_crst, "R7 chan_rst", chan_rst_o, e_crst);
    chk(done_o == e_done, "R9 done", done_o, e_done);
    chk(result_o == e_res, "R5 result", result_o, e_res);
    chk(gen2_en_o == e_gen2, "R7 gen2", gen2_en_o, e_gen2);
  end

  task automatic scenario(input logic [3:0] da, input logic [3:0] db, input int stuck,
                          input bit poke);
    @(negedge clk);
    det_a = da; det_b = db; stuck_cfg = stuck; env_clr = 1'b1;
    @(negedge clk); env_clr = 1'b0;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    for (int n = 0; n < 6000 && !done_o; n++) begin
      @(negedge clk);
      if (poke && (n % 700) == 350) start_i = 1'b1; else start_i = 1'b0;
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!err_clr_o && !ctl_wr_o && !chan_rst_o && !done_o, "R1 strobes", 0, 0);
    chk(result_o == 2'b00, "R1 result", result_o, 0);
    chk(gen2_en_o == 1'b1, "R1 gen2", gen2_en_o, 1);
    rst_n = 1'b1;
    @(negedge clk); m_on = 1'b1;
    @(negedge clk);

    scenario(4'h3, 4'h3, 0, 0);
    chk(done_o && result_o == 2'b01, "R5 found", result_o, 1);
    chk(rel_wr_n == 1, "R4 single release", rel_wr_n, 1);

    scenario(4'h3, 4'h3, 2, 0);
    chk(rel_wr_n == 3, "R4 two retries", rel_wr_n, 3);

    scenario(4'h3, 4'h3, 9, 0);
    chk(rel_wr_n == 1 + RETRIES, "R4 retry cap", rel_wr_n, 1 + RETRIES);
    chk(result_o == 2'b01, "R4 continues after cap", result_o, 1);

    scenario(4'h0, 4'h3, 0, 0);
    chk(result_o == 2'b10, "R6 no device", result_o, 2);
    chk(crst_n == 0, "R6 no fallback", crst_n, 0);

    scenario(4'h1, 4'h3, 0, 0);
    chk(result_o == 2'b01 && crst_n == 1, "R7 fallback then found", result_o, 1);
    chk(gen2_en_o == 1'b0, "R7 gen2 cleared", gen2_en_o, 0);

    scenario(4'h1, 4'h1, 0, 1);
    chk(result_o == 2'b11, "R8 failed", result_o, 3);
    chk(crst_n == 1, "R8 one fallback only", crst_n, 1);

    scenario(4'h2, 4'h0, 0, 0);
    chk(result_o == 2'b10, "R6 no device after fallback", result_o, 2);

    scenario(4'h3, 4'h3, 0, 0);
    chk(gen2_en_o == 1'b1, "R9 gen2 restored on new start", gen2_en_o, 1);
    @(negedge clk);
    chk(!done_o && result_o == 2'b01, "R9 done pulse and held result", result_o, 1);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule